// File: doc/BRIEF.md
# Raster-Position Display Interrupt Unit

This block raises a display interrupt when the scan reaches a chosen point on the screen. It holds four compare channels, and each one can be programmed on its own. A channel holds four things: a vertical target (a line number), a horizontal target, an enable mask and a sticky status flag. On every half-line tick the timing generator supplies the updated half-line count and the half-line width. Each channel then checks whether the raster has reached its position. When a channel matches, its status flag is set, and the flag stays set until software clears it.

Horizontal resolution is coarse. A channel only picks which half of the line it fires in. The second half is chosen when its horizontal target is larger than the half-line width. One interrupt line is driven from the OR of all status flags whose mask bit is set.

Software reaches the block through a simple 16-bit register port:

- Each channel has an upper word and a lower word.
- A control word provides a soft reset that clears every channel.

Top module: `raster_irq_unit`

## Requirements
- R1: Address 2n selects the upper word of channel n (n = 0..3). Its bit fields are: bits 9:0 vertical target, bit 12 mask, bit 15 status. Address 2n+1 selects the lower word, with bits 9:0 holding the horizontal target. A read returns the stored fields, and all other bits read as 0.
- R2: On a cycle with `hl_tick` high, a channel matches only if floor(`hl_count`/2)+1 equals its vertical target.
- R3: The half-line parity (`hl_count` bit 0) must also be 1 when the horizontal target is greater than `hl_width`, and 0 otherwise. An equal value therefore selects the first half.
- R4: Status bits are sticky. Hardware only sets them, and they change only on a tick or a bus write.
- R5: `irq` is high exactly when some channel holds both status and mask set. It follows the stored state in the cycle after any change.
- R6: Writing an upper word loads the vertical target, mask and status from the data. Writing status 0 clears a pending interrupt, and `irq` reflects this in the next cycle.
- R7: A write to address 8 with bit 0 set clears every field of all four channels, which drops `irq`. Address 8 and addresses 9..15 always read 0. Writes to 9..15, and writes to 8 with bit 0 clear, change nothing.
- R8: After `rst_n` is released, the channels hold these values: channel 0 has horizontal 430, vertical 263, mask 1; channel 1 has horizontal 1, vertical 1, mask 1; channels 2 and 3 are all zero, and status is 0 everywhere.
- R9: A match is evaluated against the targets held before the cycle. A match overrides a same-cycle write of status 0. A soft reset overrides a same-cycle match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hl_tick | input | 1 | One-cycle pulse; the count has just advanced |
| hl_count | input | 11 | Current half-line count of the frame |
| hl_width | input | 10 | Programmed half-line width in samples |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| irq | output | 1 | Combined display interrupt |

## Verification
Random traffic mixes ticks whose counts are steered onto a programmed line with ticks on unrelated lines. This separates a correct vertical compare from one that is off by one line or that ignores the halving of the count. Horizontal targets are drawn below, equal to and above the width, which tells the two half-line selections apart and places the boundary on the correct side of equality. Random writes spread over every address, including unused ones and the control word, and a readback follows each cycle. This shows whether writes land in the correct field and whether unused bits and addresses stay at zero. Directed cases cover the reset values, sticky flags, clearing by write, soft reset, and the same-cycle priority between a write and a match.

// File: rtl/raster_irq_pkg.sv
package raster_irq_pkg;
    localparam int CH_N    = 4;
    localparam int V_W     = 10;
    localparam int H_W     = 10;
    localparam int MSK_BIT = 12;
    localparam int STS_BIT = 15;
    localparam int CTL_RST_BIT = 0;

    typedef struct packed {
        logic           sts;
        logic           msk;
        logic [V_W-1:0] vt;
        logic [H_W-1:0] ht;
    } chan_t;

    function automatic chan_t chan_reset(int idx);
        chan_t c;
        c = '0;
        if (idx == 0) begin
            c.ht  = H_W'(430);
            c.vt  = V_W'(263);
            c.msk = 1'b1;
        end else if (idx == 1) begin
            c.ht  = H_W'(1);
            c.vt  = V_W'(1);
            c.msk = 1'b1;
        end
        return c;
    endfunction
endpackage

// File: rtl/raster_match.sv
module raster_match
    import raster_irq_pkg::*;
#(
    parameter int HL_W = 11
) (
    input  logic            hl_tick,
    input  logic [HL_W-1:0] hl_count,
    input  logic [H_W-1:0]  hl_width,
    input  logic [V_W-1:0]  vt,
    input  logic [H_W-1:0]  ht,
    output logic            hit
);
    localparam int CMP_W = ((HL_W > V_W) ? HL_W : V_W) + 1;

    logic [CMP_W-1:0] line_no;
    logic             want_odd;

    always_comb begin
        line_no  = CMP_W'(hl_count >> 1) + CMP_W'(1);
        want_odd = (ht > hl_width);
        hit      = hl_tick && (line_no == CMP_W'(vt)) && (hl_count[0] == want_odd);
    end
endmodule

// File: rtl/raster_rdmux.sv
module raster_rdmux
    import raster_irq_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  chan_t [CH_N-1:0] chans,
    input  logic [AW-1:0]    addr,
    output logic [DW-1:0]    rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < CH_N; i++) begin
            if (addr == AW'(2*i)) begin
                rdata[V_W-1:0] = chans[i].vt;
                rdata[MSK_BIT] = chans[i].msk;
                rdata[STS_BIT] = chans[i].sts;
            end else if (addr == AW'(2*i+1)) begin
                rdata[H_W-1:0] = chans[i].ht;
            end
        end
    end
endmodule

// File: rtl/raster_irq_unit.sv
module raster_irq_unit
    import raster_irq_pkg::*;
#(
    parameter int HL_W = 11,
    parameter int AW   = 4,
    parameter int DW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hl_tick,
    input  logic [HL_W-1:0] hl_count,
    input  logic [H_W-1:0]  hl_width,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic            irq
);
    localparam logic [AW-1:0] CTL_ADDR = AW'(2*CH_N);

    typedef struct packed {
        chan_t [CH_N-1:0] ch;
    } state_t;

    state_t           st_d, st_q;
    logic [CH_N-1:0]  hit_vec;
    logic [CH_N-1:0]  sts_vec;
    logic [CH_N-1:0]  msk_vec;

    // One compare engine per channel, fed from the registered targets
    for (genvar g = 0; g < CH_N; g++) begin : g_match
        raster_match #(.HL_W(HL_W)) u_match (
            .hl_tick  (hl_tick),
            .hl_count (hl_count),
            .hl_width (hl_width),
            .vt       (st_q.ch[g].vt),
            .ht       (st_q.ch[g].ht),
            .hit      (hit_vec[g])
        );
        assign sts_vec[g] = st_q.ch[g].sts;
        assign msk_vec[g] = st_q.ch[g].msk;
    end

    raster_rdmux #(.AW(AW), .DW(DW)) u_rdmux (
        .chans (st_q.ch),
        .addr  (addr),
        .rdata (rdata)
    );

    // Next-state: bus writes, then match sets, then soft reset on top
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < CH_N; i++) begin
            if (wr_en && addr == AW'(2*i)) begin
                st_d.ch[i].vt  = wdata[V_W-1:0];
                st_d.ch[i].msk = wdata[MSK_BIT];
                st_d.ch[i].sts = wdata[STS_BIT];
            end else if (wr_en && addr == AW'(2*i+1)) begin
                st_d.ch[i].ht  = wdata[H_W-1:0];
            end
            if (hit_vec[i]) begin
                st_d.ch[i].sts = 1'b1;
            end
        end
        if (wr_en && addr == CTL_ADDR && wdata[CTL_RST_BIT]) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CH_N; i++) begin
                st_q.ch[i] <= chan_reset(i);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = |(sts_vec & msk_vec);
endmodule

// File: rtl/raster_irq_checks.sv
module raster_irq_checks
    import raster_irq_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hl_tick,
    input logic            wr_en,
    input logic [AW-1:0]   addr,
    input logic [DW-1:0]   wdata,
    input logic [DW-1:0]   rdata,
    input logic            irq,
    input logic [CH_N-1:0] sts_vec,
    input logic [CH_N-1:0] msk_vec
);
    localparam logic [AW-1:0] CTL_ADDR = AW'(2*CH_N);

    // R4: without a bus write no status bit ever falls
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((sts_vec & $past(sts_vec)) == $past(sts_vec)));

    // R4: with neither tick nor write the flags hold
    assert_quiet_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hl_tick && !wr_en) |=> $stable(sts_vec));

    // R7: soft reset empties every channel and drops the line
    assert_soft_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CTL_ADDR && wdata[CTL_RST_BIT]) |=>
            (!irq && sts_vec == '0 && msk_vec == '0));

    // R7: control and unused words read as zero
    assert_ctl_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= CTL_ADDR) |-> (rdata == '0));

    // R5: no enabled channel means no interrupt
    assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_vec == '0) |-> !irq);
endmodule

bind raster_irq_unit raster_irq_checks #(.AW(AW), .DW(DW)) u_checks (
    .clk     (clk),
    .rst_n   (rst_n),
    .hl_tick (hl_tick),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .irq     (irq),
    .sts_vec (sts_vec),
    .msk_vec (msk_vec)
);

// File: tb/raster_irq_unit_test.sv
module raster_irq_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hl_tick = 1'b0;
    logic [10:0] hl_count = '0;
    logic [9:0]  hl_width = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_v[4], m_h[4];
    bit m_m[4], m_s[4];

    always #5 clk = ~clk;

    raster_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .hl_tick(hl_tick), .hl_count(hl_count),
        .hl_width(hl_width), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_v[i] = 0; m_h[i] = 0; m_m[i] = 0; m_s[i] = 0;
        end
        m_h[0] = 430; m_v[0] = 263; m_m[0] = 1;
        m_h[1] = 1;   m_v[1] = 1;   m_m[1] = 1;
    endtask

    function automatic bit exp_hit(int i, bit tk, int cnt, int w);
        bit want_odd;
        want_odd = (m_h[i] > w);
        return tk && ((cnt / 2 + 1) == m_v[i]) && ((cnt % 2) == int'(want_odd));
    endfunction

    function automatic int exp_rd(int a);
        int r;
        r = 0;
        if (a < 8) begin
            if (a % 2 == 0) r = m_v[a/2] | (int'(m_m[a/2]) << 12) | (int'(m_s[a/2]) << 15);
            else            r = m_h[a/2];
        end
        return r;
    endfunction

    function automatic bit exp_irq();
        bit x;
        x = 0;
        for (int i = 0; i < 4; i++) x = x | (m_s[i] & m_m[i]);
        return x;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model after posedge
    task automatic cyc(bit wr, int a, int d, bit tk, int cnt, int w);
        bit hits[4];
        @(negedge clk);
        wr_en = wr; addr = 4'(a); wdata = 16'(d); hl_tick = tk;
        hl_count = 11'(cnt); hl_width = 10'(w);
        @(posedge clk); #1;
        for (int i = 0; i < 4; i++) hits[i] = exp_hit(i, tk, cnt & 11'h7ff, w);
        if (wr && a == 8 && (d & 1)) begin
            for (int i = 0; i < 4; i++) begin
                m_v[i] = 0; m_h[i] = 0; m_m[i] = 0; m_s[i] = 0;
            end
        end else begin
            if (wr && a < 8) begin
                if (a % 2 == 0) begin
                    m_v[a/2] = d & 10'h3ff;
                    m_m[a/2] = (d >> 12) & 1;
                    m_s[a/2] = (d >> 15) & 1;
                end else begin
                    m_h[a/2] = d & 10'h3ff;
                end
            end
            for (int i = 0; i < 4; i++) if (hits[i]) m_s[i] = 1;
        end
        wr_en = 0; hl_tick = 0;
    endtask

    task automatic chk_rd(int a, string tag);
        addr = 4'(a);
        #1;
        check(tag, int'(rdata), exp_rd(a));
    endtask

    task automatic chk_irq(string tag);
        check(tag, int'(irq), int'(exp_irq()));
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R8: reset values on every word
        for (int a = 0; a < 8; a++) chk_rd(a, "R8 reset word");
        chk_irq("R8 reset irq");

        // R2 R3: channel 1 fires at line 1, first half (h=1 not > w=100)
        cyc(0, 0, 0, 1, 1, 100);       // parity 1: no hit
        chk_rd(2, "R3 wrong half no set");
        cyc(0, 0, 0, 1, 0, 100);       // line 1, parity 0
        chk_rd(2, "R2 line match sets status");
        chk_irq("R5 irq after match");

        // R3: h equal to width selects first half
        cyc(1, 5, 200, 0, 0, 0);       // ch2 ht=200
        cyc(1, 4, 5 | (1 << 12), 0, 0, 0); // ch2 vt=5 mask
        cyc(0, 0, 0, 1, 9, 200);       // odd half, h==w -> no
        chk_rd(4, "R3 equal width not second half");
        cyc(0, 0, 0, 1, 9, 199);       // h>w -> odd half matches
        chk_rd(4, "R3 greater selects second half");

        // R2: off-by-one lines do not match
        cyc(1, 6, 0, 0, 0, 0);
        cyc(1, 7, 0, 0, 0, 0);
        cyc(1, 6, 7 | (1 << 12), 0, 0, 0);
        cyc(0, 0, 0, 1, 14, 10);       // line 8
        cyc(0, 0, 0, 1, 10, 10);       // line 6
        chk_rd(6, "R2 neighbour lines no set");

        // R4: sticky over idle and non-matching ticks
        repeat (4) cyc(0, 0, 0, 1, 500, 10);
        chk_rd(2, "R4 status stays set");

        // R6: clear by writing status 0
        cyc(1, 2, 1 | (1 << 12), 0, 0, 0);
        chk_rd(2, "R6 write clears status");
        cyc(1, 4, 5 | (1 << 12), 0, 0, 0);
        chk_irq("R6 irq follows clear");

        // R9: match beats same-cycle clear; old targets used
        cyc(1, 2, 1 | (1 << 12), 1, 0, 100);
        chk_rd(2, "R9 match wins over clear");
        cyc(1, 2, 50 | (1 << 12), 1, 0, 100); // targets changed same cycle: old vt=1 hits
        chk_rd(2, "R9 old target compared");

        // R7: ignored control and unused writes
        cyc(1, 8, 16'hfffe, 0, 0, 0);
        cyc(1, 11, 16'hffff, 0, 0, 0);
        for (int a = 0; a < 16; a++) chk_rd(a, "R7 ignored writes");

        // R7 R9: soft reset beats same-cycle match
        cyc(1, 8, 1, 1, 0, 100);
        for (int a = 0; a < 16; a++) chk_rd(a, "R7 soft reset clears");
        chk_irq("R7 irq after soft reset");

        // R1: unused bits read zero
        cyc(1, 3, 16'hffff, 0, 0, 0);
        chk_rd(3, "R1 lower word fields");
        cyc(1, 0, 16'h6c00 | 123, 0, 0, 0);
        chk_rd(0, "R1 upper word fields");

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            bit wr, tk;
            int a, d, cnt, w, ch;
            wr  = ($urandom % 4) == 0;
            a   = ($urandom % 5 == 0) ? ($urandom % 16) : ($urandom % 8);
            if (a == 8 && ($urandom % 8 != 0)) a = 9;
            d   = $urandom & 16'hffff;
            if (a % 2 == 0 && a < 8 && ($urandom % 2)) d = (d & 16'hfc00) | ($urandom % 12);
            tk  = ($urandom % 2) == 1;
            ch  = $urandom % 4;
            cnt = ($urandom % 2) ? ((2 * (m_v[ch] - 1) + ($urandom % 2)) & 11'h7ff)
                                 : ($urandom % 2048);
            case ($urandom % 3)
                0: w = m_h[ch];
                1: w = (m_h[ch] == 0) ? 0 : m_h[ch] - 1;
                default: w = $urandom % 1024;
            endcase
            cyc(wr, a, d, tk, cnt, w);
            chk_irq("R5 random irq");
            chk_rd($urandom % 16, "R1 random readback");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule